// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Staged Configuration

This block drives several independent pulse-width-modulated outputs from one clock. For each channel, software sets three unsigned 32-bit cycle counts: the period, the high time, and a delay from the start of each period to the start of the high time. These values are written over a simple word-addressed register bus into staging (shadow) registers. A staged value has no effect on any output until software writes the commit command to the control register.

On a commit, every channel's staged values move into its live registers in the same clock edge. At that edge the counter of every channel restarts from zero, so all channels come out of a commit phase-aligned. A second control bit freezes all counters and forces all outputs low for as long as it is set. A fixed identification word and a channel-count word can be read so that software can discover the block.

Top module: `pwm_multichan`

## Requirements
- R1: A write to a channel's period, duty or offset register updates only the staging copy. Live configuration and outputs do not change until a commit.
- R2: Writing 1 to bit 1 of the control register (offset 0x10) is a commit. At that clock edge, every channel's staged values become live and every counter restarts at 0. In the first cycle after that edge, each output shows phase 0.
- R3: While the live period P is nonzero, the counter steps 0,1,...,P-1 and then wraps. The output is high exactly when offset <= count and count - offset < duty.
- R4: When offset + duty exceeds the period, the output stays high from the offset until the counter wraps. It then goes low again at count 0.
- R5: A duty of 0 gives a constant low output. A duty >= period with offset 0 gives a constant high output.
- R6: A channel whose live period is 0 is disabled. Its counter stays at 0 and its output stays low.
- R7: Bit 0 of the control register is a hold bit that reads back as written. While it is 1, every counter is held at 0 and every output is low. After it is cleared, counting resumes from phase 0. The commit bit always reads back as 0.
- R8: Offset 0x00 is read-only and returns 0x601A3471.
- R9: Offset 0x14 is read-only and returns the number of channels.
- R10: Staging registers read back the last value written. Periods are at 0x40, duties at 0x80 and offsets at 0xC0, each plus 4 x channel. Every unmapped offset reads 0. Read data appears in the cycle after the read strobe.
- R11: After reset, all outputs are low and all registers read 0 except the identification and channel-count words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; all counts are in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
Read data is due one cycle after the strobe. The bench captures the strobe in a one-cycle delay flag, and the monitor compares the queued expectation only in the cycle that flag is set. Outputs are combinational from the counters. The first cycle after a commit or a hold-release edge is therefore phase 0, and each later sample advances the phase by exactly one. The bench counts phase from that edge and samples every output on the falling clock edge. Phase-independent cases, such as a staged change on a constant-high channel, are checked over a run of cycles without any phase bookkeeping.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;

    localparam int          WORD_W        = 32;
    localparam int          ADDR_W        = 8;
    localparam int          SLOT_W        = 4;   // up to 16 channels per group
    localparam logic [31:0] BLOCK_ID      = 32'h601A3471;

    localparam logic [ADDR_W-1:0] ADR_ID   = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 8'h10;
    localparam logic [ADDR_W-1:0] ADR_NCH  = 8'h14;

    localparam int CTRL_HOLD_BIT = 0;
    localparam int CTRL_LOAD_BIT = 1;

    typedef struct packed {
        logic [WORD_W-1:0] period;
        logic [WORD_W-1:0] duty;
        logic [WORD_W-1:0] offset;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        FLD_NONE = 2'b00,
        FLD_PER  = 2'b01,
        FLD_DUTY = 2'b10,
        FLD_OFFS = 2'b11
    } fld_e;

    // upper address bits select the per-channel register group
    function automatic fld_e field_of(input logic [1:0] grp);
        return fld_e'(grp);
    endfunction

    function automatic logic in_window(input logic [WORD_W-1:0] cnt,
                                       input chan_cfg_t cfg);
        return (cnt >= cfg.offset) && ((cnt - cfg.offset) < cfg.duty);
    endfunction

endpackage

// File: rtl/pwmgen_regs.sv
module pwmgen_regs
    import pwmgen_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_we,
    input  logic                          bus_re,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [WORD_W-1:0]             bus_wdata,
    output logic [WORD_W-1:0]             bus_rdata,
    output chan_cfg_t [NUM_CH-1:0]        act_o,
    output logic                          load_o,
    output logic                          hold_o
);

    logic [SLOT_W-1:0]      slot;
    fld_e                   fld;
    logic                   aligned;
    chan_cfg_t [NUM_CH-1:0] shd_q;
    chan_cfg_t [NUM_CH-1:0] act_q;
    logic                   hold_q;
    logic [WORD_W-1:0]      rd_mux;
    logic [WORD_W-1:0]      rdata_q;

    assign slot    = bus_addr[5:2];
    assign fld     = field_of(bus_addr[7:6]);
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign load_o  = bus_we && (bus_addr == ADR_CTRL) && bus_wdata[CTRL_LOAD_BIT];

    // staging bank, one writer per channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (rst) begin
                shd_q[ch] <= '0;
            end else if (bus_we && aligned && slot == SLOT_W'(ch)) begin
                case (fld)
                    FLD_PER:  shd_q[ch].period <= bus_wdata;
                    FLD_DUTY: shd_q[ch].duty   <= bus_wdata;
                    FLD_OFFS: shd_q[ch].offset <= bus_wdata;
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         act_q <= '0;
        else if (load_o) act_q <= shd_q;
    end

    always_ff @(posedge clk) begin
        if (rst)                                    hold_q <= 1'b0;
        else if (bus_we && bus_addr == ADR_CTRL)    hold_q <= bus_wdata[CTRL_HOLD_BIT];
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADR_ID) begin
            rd_mux = BLOCK_ID;
        end else if (bus_addr == ADR_CTRL) begin
            rd_mux[CTRL_HOLD_BIT] = hold_q;
        end else if (bus_addr == ADR_NCH) begin
            rd_mux = WORD_W'(NUM_CH);
        end else if (aligned) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (slot == SLOT_W'(c)) begin
                    case (fld)
                        FLD_PER:  rd_mux = shd_q[c].period;
                        FLD_DUTY: rd_mux = shd_q[c].duty;
                        FLD_OFFS: rd_mux = shd_q[c].offset;
                        default:  ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_re) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign act_o     = act_q;
    assign hold_o    = hold_q;

    AST_LIVE_STABLE_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !load_o |=> act_q == $past(act_q)); // R1
    AST_COMMIT_COPIES_STAGE: assert property (@(posedge clk) disable iff (rst)
        load_o |=> act_q == $past(shd_q)); // R2
    AST_COMMIT_BIT_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == ADR_CTRL) |=> !bus_rdata[CTRL_LOAD_BIT]); // R7
    AST_ID_WORD: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == ADR_ID) |=> bus_rdata == BLOCK_ID); // R8

endmodule

// File: rtl/pwmgen_chan.sv
module pwmgen_chan
    import pwmgen_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hold_i,
    input  logic      load_i,
    input  chan_cfg_t cfg_i,
    output logic      pwm_o
);

    logic [WORD_W-1:0] cnt_q;
    logic              idle;
    logic              wrap;

    assign idle = (cfg_i.period == '0);
    assign wrap = (cnt_q >= cfg_i.period - WORD_W'(1));

    always_ff @(posedge clk) begin
        if (rst || hold_i || load_i || idle) cnt_q <= '0;
        else if (wrap)                       cnt_q <= '0;
        else                                 cnt_q <= cnt_q + WORD_W'(1);
    end

    assign pwm_o = !hold_i && !idle && in_window(cnt_q, cfg_i);

    AST_COMMIT_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        load_i |=> cnt_q == '0); // R2
    AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (!idle && !load_i) |=> cnt_q < cfg_i.period); // R3
    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (idle && !load_i) |=> cnt_q == '0); // R6
    AST_HOLD_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> cnt_q == '0); // R7

endmodule

// File: rtl/pwm_multichan.sv
module pwm_multichan
    import pwmgen_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    chan_cfg_t [NUM_CH-1:0] live_cfg;
    logic                   commit;
    logic                   hold;

    pwmgen_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .act_o     (live_cfg),
        .load_o    (commit),
        .hold_o    (hold)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        pwmgen_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .hold_i (hold),
            .load_i (commit),
            .cfg_i  (live_cfg[ch]),
            .pwm_o  (pwm_out[ch])
        );
    end

    AST_HOLD_OUTPUTS_LOW: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADR_CTRL && bus_wdata[CTRL_HOLD_BIT]) |=> pwm_out == '0); // R7

endmodule

// File: tb/pwm_multichan_bench.sv
module pwm_multichan_bench;

    localparam int NCH = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_we = 1'b0;
    logic            bus_re = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCH-1:0]  pwm_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [31:0] v;
        string       tag;
    } rd_item_t;
    rd_item_t rd_q[$];
    logic     rd_seen = 1'b0;

    int unsigned stg_p[NCH], stg_d[NCH], stg_o[NCH];
    int unsigned liv_p[NCH], liv_d[NCH], liv_o[NCH];
    string       ch_tag[NCH];

    always #10 clk = ~clk;   // 50 MHz

    pwm_multichan #(.NUM_CH(NCH)) u_pwm_multichan (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic bit model(input int unsigned k, input int unsigned p,
                                 input int unsigned d, input int unsigned o);
        int unsigned ph;
        if (p == 0) return 1'b0;
        ph = k % p;
        return (ph >= o) && ((ph - o) < d);
    endfunction

    always @(posedge clk) rd_seen <= bus_re;

    // monitor: pops one expectation per completed read
    always @(negedge clk) begin
        if (rd_seen) begin
            rd_item_t it;
            if (rd_q.size() == 0) begin
                chk(1'b0, "R10 unexpected read data", bus_rdata, 32'h0);
            end else begin
                it = rd_q.pop_front();
                chk(bus_rdata === it.v, it.tag, bus_rdata, it.v);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        rd_item_t it;
        it.v = exp; it.tag = tag;
        @(negedge clk);
        rd_q.push_back(it);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic stage(input int ch, input int unsigned p, input int unsigned d, input int unsigned o);
        wr(8'(8'h40 + 4 * ch), p); stg_p[ch] = p;
        wr(8'(8'h80 + 4 * ch), d); stg_d[ch] = d;
        wr(8'(8'hC0 + 4 * ch), o); stg_o[ch] = o;
    endtask

    task automatic commit();
        wr(8'h10, 32'h2);
        for (int c = 0; c < NCH; c++) begin
            liv_p[c] = stg_p[c]; liv_d[c] = stg_d[c]; liv_o[c] = stg_o[c];
        end
    endtask

    // phase 0 is the sample right after the aligning edge
    task automatic watch(input int n, input string pre);
        for (int k = 0; k < n; k++) begin
            for (int c = 0; c < NCH; c++) begin
                bit e;
                e = model(k, liv_p[c], liv_d[c], liv_o[c]);
                chk(pwm_out[c] === e, $sformatf("%s %s ch%0d phase %0d", pre, ch_tag[c], c, k),
                    32'(pwm_out[c]), 32'(e));
            end
            @(negedge clk);
        end
    endtask

    task automatic expect_low(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            chk(pwm_out === '0, tag, 32'(pwm_out), 32'h0);
            @(negedge clk);
        end
    endtask

    initial begin
        #(20ns * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            stg_p[c] = 0; stg_d[c] = 0; stg_o[c] = 0;
            liv_p[c] = 0; liv_d[c] = 0; liv_o[c] = 0;
        end
        ch_tag[0] = "R3"; ch_tag[1] = "R4"; ch_tag[2] = "R5"; ch_tag[3] = "R5";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk(pwm_out === '0, "R11 outputs after reset", 32'(pwm_out), 32'h0);
        rd(8'h00, 32'h601A3471, "R8 id word");
        rd(8'h14, 32'(NCH), "R9 channel count");
        rd(8'h10, 32'h0, "R11 control after reset");
        rd(8'h84, 32'h0, "R11 staging after reset");

        // R1 staged values leave outputs untouched
        stage(0, 10, 3, 2);
        stage(1, 8, 5, 6);
        stage(2, 9, 0, 1);
        stage(3, 10, 12, 0);
        expect_low(12, "R1 staged only");

        // R10 readback and unmapped
        rd(8'h84, 32'd5,  "R10 duty ch1");
        rd(8'hC4, 32'd6,  "R10 offset ch1");
        rd(8'h4C, 32'd10, "R10 period ch3");
        rd(8'h50, 32'h0,  "R10 unmapped 0x50");
        rd(8'h20, 32'h0,  "R10 unmapped 0x20");
        rd(8'h42, 32'h0,  "R10 unaligned 0x42");

        // R2 commit aligns all channels
        commit();
        watch(30, "R2");
        rd(8'h10, 32'h0, "R7 commit bit reads 0");

        // R1 staged change on constant-high channel
        wr(8'h4C, 32'd0); stg_p[3] = 0;
        wr(8'h80, 32'd6); stg_d[0] = 6;
        for (int k = 0; k < 10; k++) begin
            chk(pwm_out[3] === 1'b1, "R1 ch3 keeps live config", 32'(pwm_out[3]), 32'h1);
            @(negedge clk);
        end

        // R6 zero period disables after commit
        ch_tag[3] = "R6";
        commit();
        watch(20, "R2");

        // R7 hold
        wr(8'h10, 32'h1);
        expect_low(15, "R7 hold forces low");
        rd(8'h10, 32'h1, "R7 hold reads back");
        wr(8'h10, 32'h0);
        watch(20, "R7");

        repeat (3) @(negedge clk);
        chk(rd_q.size() == 0, "R10 all reads answered", rd_q.size(), 32'h0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule